// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor port and a slower main-memory port. It serves byte reads and byte writes from a unified store. The store is organised as sets of two lines, and each line holds one block of `2**OFF_W` bytes. Every processor byte address is split into three fields: a byte offset inside the block, a set index, and a tag. When the processor asks for an address, the block looks up the indexed set and compares both stored tags against the request tag.

On a hit, the access completes from the matching line and main memory is not touched. On a miss, a victim line is picked inside the indexed set. An invalid line is taken first. When both lines are valid, the line that was filled earliest is taken. If the victim holds modified data, it is first written back to memory as a whole block. The requested block is then fetched, installed and used to finish the access.

Writes never go to memory directly. A write only changes the cached line and marks it modified. The processor holds its request until a one-cycle ready pulse comes back. The memory side moves one whole block per request, using a request/acknowledge handshake.

Top module: `cache2w_wb`

## Requirements
- R1: Address fields are byte offset = `addr[OFF_W-1:0]`, set = `addr[OFF_W+SET_W-1:OFF_W]`, and tag = the remaining upper bits. With `ADDR_W=24`, `OFF_W=2` and `SET_W=13`, this gives a 9-bit tag. Block address on the memory port = `{tag, set}`. Byte k of a block sits in data bits `[8k+7:8k]`.
- R2: A synchronous active-high reset clears every valid bit, every modified bit and every per-set order bit, and it drops `core_ready` and `mem_req`. The first access to any address after reset is therefore a miss.
- R3: A read hit returns the addressed byte with `core_ready` high exactly two clock edges after the request is first seen, and it causes no memory transfer.
- R4: A read miss issues exactly one block fetch (`mem_we`=0) for the request's block address. The byte taken from the fetched block is delivered with `core_ready` in the cycle after `mem_ack`.
- R5: A write hit changes only the cached byte, issues no memory transfer, and marks the line modified. A later read returns the written byte.
- R6: A write miss fetches the block and merges the written byte into it while filling. Afterwards the line is resident and modified.
- R7: The victim is an invalid line if one exists, with way 0 before way 1. Otherwise the victim is the line filled longest ago. Hits do not change this order.
- R8: A modified victim is written back as one block (`mem_we`=1) to `{old tag, set}` with its full current contents, before the fetch of the new block.
- R9: An unmodified victim is dropped without any memory write.
- R10: `core_ready` is a single-cycle pulse. While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Processor access request, held until `core_ready` |
| core_we | input | 1 | 1 = byte write, 0 = byte read |
| core_addr | input | ADDR_W | Byte address |
| core_wdata | input | 8 | Byte to write |
| core_rdata | output | 8 | Byte read (registered) |
| core_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory block request, held until `mem_ack` |
| mem_we | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wdata | output | 8*2**OFF_W | Block data written back |
| mem_rdata | input | 8*2**OFF_W | Fetched block, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |

## Verification
Two functions can land in the same clock edge.

The first pair is the completion of a block fetch and the merge of a processor write byte. Both happen in the single fill cycle of a write miss. Write misses are driven into sets whose victims are already modified, so a write-back, a fetch and a merge all follow one another. The bench then judges the result in two ways:
- a later read of every byte must match an arithmetic shadow of memory;
- the next write-back of that block must carry the merged byte.

The second pair is the write-back handshake completing and the fetch request being presented. These fall on consecutive edges with `mem_req` held high throughout. The bench memory model checks that the address and direction change only after its acknowledge.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_WBACK = 2'd2,
    ST_FETCH = 2'd3
  } cstate_t;
endpackage

// File: rtl/cache2w_way_store.sv
// One way: tag and block data in a simple dual-port RAM with registered read.
module cache2w_way_store #(
  parameter int SET_W  = 8,
  parameter int TAG_W  = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  rd_set,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << SET_W;
  localparam int ENT_W = TAG_W + DATA_W;

  logic [ENT_W-1:0] ram [SETS];
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_set] <= {wr_tag, wr_data};
    rd_q <= ram[rd_set];
  end

  assign rd_tag  = rd_q[ENT_W-1:DATA_W];
  assign rd_data = rd_q[DATA_W-1:0];
endmodule

// File: rtl/cache2w_line_state.sv
// Per-set valid, modified and fill-order bits, all cleared by reset.
module cache2w_line_state #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic             fill_dirty,
  input  logic             mark_en,
  input  logic             mark_way,
  output logic [1:0]       vld,
  output logic [1:0]       drt,
  output logic             order
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] vld_q [2];
  logic [SETS-1:0] drt_q [2];
  logic [SETS-1:0] ord_q;

  genvar w;
  generate
    for (w = 0; w < 2; w++) begin : g_way
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q[w] <= '0;
          drt_q[w] <= '0;
        end else if (fill_en && (fill_way == w[0])) begin
          vld_q[w][set_idx] <= 1'b1;
          drt_q[w][set_idx] <= fill_dirty;
        end else if (mark_en && (mark_way == w[0])) begin
          drt_q[w][set_idx] <= 1'b1;
        end
      end
      assign vld[w] = vld_q[w][set_idx];
      assign drt[w] = drt_q[w][set_idx];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ord_q <= '0;
    else if (fill_en) ord_q[set_idx] <= ~ord_q[set_idx];
  end

  assign order = ord_q[set_idx];
endmodule

// File: rtl/cache2w_victim.sv
// Victim choice: first invalid way (way 0 first), else the oldest fill.
module cache2w_victim (
  input  logic [1:0] vld,
  input  logic       order,
  output logic       way
);
  always_comb begin
    if (!vld[0])      way = 1'b0;
    else if (!vld[1]) way = 1'b1;
    else              way = order;
  end
endmodule

// File: rtl/cache2w_wb.sv
module cache2w_wb
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 2,
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
  localparam int BLK_AW = ADDR_W - OFF_W,
  localparam int DATA_W = 8 << OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [7:0]        core_wdata,
  output logic [7:0]        core_rdata,
  output logic              core_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  cstate_t st;

  logic              req_we;
  logic [TAG_W-1:0]  req_tag;
  logic [SET_W-1:0]  req_set;
  logic [OFF_W-1:0]  req_off;
  logic [7:0]        req_byte;
  logic              vic_q;

  logic [TAG_W-1:0]  rd_tag  [WAYS];
  logic [DATA_W-1:0] rd_data [WAYS];
  logic [WAYS-1:0]   way_wr;
  logic [WAYS-1:0]   hit_vec;
  logic [1:0]        vld, drt;
  logic              order, vic_way, hit, hit_way;
  logic              fill_en, mark_en;
  logic [DATA_W-1:0] merge_base, merged;
  logic [OFF_W+2:0]  bsel;

  assign bsel = {req_off, 3'b000};

  // Lookup compare, one per way
  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w] = vld[w] && (rd_tag[w] == req_tag);
      assign way_wr[w]  = (st == ST_LOOK && hit_vec[w] && req_we) ||
                          (fill_en && (vic_q == w[0]));

      cache2w_way_store #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk     (clk),
        .rd_set  (core_addr[OFF_W +: SET_W]),
        .rd_tag  (rd_tag[w]),
        .rd_data (rd_data[w]),
        .wr_en   (way_wr[w]),
        .wr_set  (req_set),
        .wr_tag  (req_tag),
        .wr_data (merged)
      );
    end
  endgenerate

  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];
  assign fill_en = (st == ST_FETCH) && mem_ack;
  assign mark_en = (st == ST_LOOK) && hit && req_we;

  cache2w_line_state #(.SET_W(SET_W)) state_i (
    .clk        (clk),
    .rst        (rst),
    .set_idx    (req_set),
    .fill_en    (fill_en),
    .fill_way   (vic_q),
    .fill_dirty (req_we),
    .mark_en    (mark_en),
    .mark_way   (hit_way),
    .vld        (vld),
    .drt        (drt),
    .order      (order)
  );

  cache2w_victim victim_i (
    .vld   (vld),
    .order (order),
    .way   (vic_way)
  );

  // Block merge of a write byte into either the fetched or the cached block
  always_comb begin
    merge_base = (st == ST_FETCH) ? mem_rdata : rd_data[hit_way];
    merged     = merge_base;
    if (req_we) merged[bsel +: 8] = req_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      core_ready <= 1'b0;
      core_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      req_we     <= 1'b0;
      req_tag    <= '0;
      req_set    <= '0;
      req_off    <= '0;
      req_byte   <= '0;
      vic_q      <= 1'b0;
    end else begin
      core_ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (core_req) begin
            req_we   <= core_we;
            req_tag  <= core_addr[ADDR_W-1 -: TAG_W];
            req_set  <= core_addr[OFF_W +: SET_W];
            req_off  <= core_addr[OFF_W-1:0];
            req_byte <= core_wdata;
            st       <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            core_rdata <= merged[bsel +: 8];
            core_ready <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            vic_q   <= vic_way;
            mem_req <= 1'b1;
            if (vld[vic_way] && drt[vic_way]) begin
              mem_we    <= 1'b1;
              mem_addr  <= {rd_tag[vic_way], req_set};
              mem_wdata <= rd_data[vic_way];
              st        <= ST_WBACK;
            end else begin
              mem_we   <= 1'b0;
              mem_addr <= {req_tag, req_set};
              st       <= ST_FETCH;
            end
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= {req_tag, req_set};
            st       <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            core_rdata <= merged[bsel +: 8];
            core_ready <= 1'b1;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int BLK_AW = 22,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              core_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [BLK_AW-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);
  a_r2_reset_quiet: assert property (@(posedge clk)
    rst |=> (!core_ready && !mem_req));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_addr) && $stable(mem_wdata)));

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    core_ready |=> !core_ready);

  a_r8_wb_then_fetch: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  a_r4_fill_then_ready: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack) |=> core_ready);

  a_r3_ready_no_traffic: assert property (@(posedge clk) disable iff (rst)
    core_ready |-> !mem_req);
endmodule

bind cache2w_wb cache2w_chk #(.BLK_AW(BLK_AW), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .core_ready (core_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack)
);

// File: tb/cache2w_wb_tb_top.sv
`timescale 1ns/1ps
module cache2w_wb_tb_top;
  localparam int AW = 8, SW = 2, OW = 2;
  localparam int NSET = 1 << SW;
  localparam int NBLK = 1 << (AW - OW);
  localparam int NBYTE = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        core_req = 1'b0, core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [7:0]  core_wdata = '0, core_rdata;
  logic        core_ready, mem_req, mem_we;
  logic [AW-OW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  cache2w_wb #(.ADDR_W(AW), .SET_W(SW), .OFF_W(OW)) dut_i (
    .clk(clk), .rst(rst), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .core_ready(core_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  int total = 0, bad = 0;
  logic [31:0] bmem [NBLK];
  logic [7:0]  gold [NBYTE];
  int nrd = 0, nwr = 0, mcnt = 0, mlat = 1;
  logic [AW-OW-1:0] last_wba;
  logic [31:0] last_wbd;
  logic [AW-OW-1:0] last_rda;

  // shadow of line state, from the requirements
  int  mt [NSET][2];
  bit  mv [NSET][2];
  bit  md [NSET][2];
  bit  mp [NSET];

  // memory model
  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (mcnt >= mlat) begin
        mcnt = 0;
        if (mem_we) begin
          bmem[mem_addr] = mem_wdata;
          last_wba = mem_addr; last_wbd = mem_wdata; nwr++;
        end else begin
          mem_rdata <= bmem[mem_addr];
          last_rda = mem_addr; nrd++;
        end
        mem_ack <= 1'b1;
      end else mcnt++;
    end
  end

  int cyc_all = 0;
  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all == 190000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] gold_blk(input int b);
    return {gold[4*b+3], gold[4*b+2], gold[4*b+1], gold[4*b]};
  endfunction

  task automatic model_clear();
    for (int s = 0; s < NSET; s++) begin
      mp[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0; end
    end
  endtask

  // one access; returns whether memory was fetched
  task automatic access(input bit we, input int a, input logic [7:0] d, output bit fetched);
    int s, t, hw, vw, cyc, rd0, wr0, wba;
    bit hit, expwb;
    s = (a >> OW) % NSET; t = a >> (OW + SW);
    hit = 0; hw = 0; vw = 0; expwb = 0;
    for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == t) begin hit = 1; hw = w; end
    if (!hit) begin
      vw = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(mp[s]));  // R7
      expwb = mv[s][vw] && md[s][vw];
    end
    wba = (mt[s][vw] << SW) | s;
    rd0 = nrd; wr0 = nwr;
    @(negedge clk);
    core_req = 1; core_we = we; core_addr = a[AW-1:0]; core_wdata = d;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!core_ready && cyc < 500);
    core_req = 0;
    chk(cyc < 500, "R10 completion", cyc, 0);
    if (hit) begin
      chk(cyc == 2, "R3 hit latency", cyc, 2);
      chk(nrd == rd0 && nwr == wr0, we ? "R5 write hit traffic" : "R3 read hit traffic",
          (nrd - rd0) + (nwr - wr0), 0);
    end else begin
      chk(nrd - rd0 == 1, we ? "R6 write miss fetch" : "R4 read miss fetch", nrd - rd0, 1);
      chk(last_rda == a[AW-1:OW], "R1 fetch address", last_rda, a >> OW);
      chk(nwr - wr0 == int'(expwb), expwb ? "R8 write-back" : "R9 clean drop",
          nwr - wr0, expwb);
      if (expwb) begin
        chk(last_wba == wba[AW-OW-1:0], "R8 write-back address", last_wba, wba);
        chk(last_wbd == gold_blk(wba), "R8 write-back data", last_wbd, gold_blk(wba));
      end
    end
    if (!we) chk(core_rdata == gold[a], hit ? "R3 read data" : "R4 read data", core_rdata, gold[a]);
    else gold[a] = d;
    if (hit) begin
      if (we) md[s][hw] = 1;
    end else begin
      mt[s][vw] = t; mv[s][vw] = 1; md[s][vw] = we; mp[s] = ~mp[s];
    end
    fetched = !hit;
  endtask

  initial begin
    bit f;
    logic [15:0] lfsr;
    for (int b = 0; b < NBLK; b++) begin
      for (int k = 0; k < 4; k++) gold[4*b+k] = 8'((4*b + k) * 7 + 3);
      bmem[b] = gold_blk(b);
    end
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!core_ready && !mem_req, "R2 reset outputs", {core_ready, mem_req}, 0);
    rst = 0;

    // R7/R8 fill order: A,B fill set 0; hit A; C must replace A (oldest), not B
    access(0, 8'h10, 0, f); chk(f, "R2 first access misses", f, 1);
    access(0, 8'h20, 0, f);
    access(0, 8'h11, 0, f); chk(!f, "R7 A resident", f, 0);
    access(0, 8'h30, 0, f);
    access(0, 8'h21, 0, f); chk(!f, "R7 B kept after C", f, 0);
    access(0, 8'h12, 0, f); chk(f, "R7 oldest A replaced", f, 1);

    // full read sweep, then write sweep, then readback
    for (int a = 0; a < NBYTE; a++) begin mlat = a % 4; access(0, a, 0, f); end
    for (int a = 0; a < NBYTE; a++) access(1, (a * 37) % NBYTE, 8'(a ^ 8'h5A), f);
    for (int a = 0; a < NBYTE; a++) access(0, a, 0, f);

    // R6 write miss into set with dirty victims, merge check
    for (int a = 0; a < NBYTE; a += 16) access(1, a + 5, 8'(a + 1), f);
    for (int a = 0; a < NBYTE; a += 16) access(0, a + 5, 0, f);

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mlat = lfsr[9:8];
      access(lfsr[0], int'(lfsr[15:8]), lfsr[7:0], f);
    end

    // R2 reset mid-run: all lines invalid, modified data discarded
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    model_clear();
    for (int b = 0; b < NBLK; b++)
      for (int k = 0; k < 4; k++) gold[4*b+k] = bmem[b][8*k +: 8];
    access(0, 8'h44, 0, f); chk(f, "R2 miss after reset", f, 1);
    for (int a = 0; a < 64; a++) access(1, a * 4 + 2, 8'(~a), f);
    for (int a = 0; a < NBYTE; a++) access(0, a, 0, f);

    // backing memory must equal shadow for every block not held modified
    for (int b = 0; b < NBLK; b++) begin
      int s, t; bit held;
      s = b % NSET; t = b / NSET; held = 0;
      for (int w = 0; w < 2; w++) if (mv[s][w] && md[s][w] && mt[s][w] == t) held = 1;
      if (!held) chk(bmem[b] == gold_blk(b), "R8 memory image", bmem[b], gold_blk(b));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule